// File: doc/BRIEF.md
# Stack push/pop sequencer

This block moves one 16-bit register pair between a byte-wide register file and byte-wide memory through a 16-bit stack pointer. A 16-bit value crosses an 8-bit memory port, so each command takes two byte transfers. A command gives a direction and a pair select. The sequencer then drives the memory address, write data and the write and read strobes, and it returns popped bytes through a register write-back port. It pulses done when the command is complete.

The stack grows downward. A push decrements the pointer before each byte it stores. A pop increments the pointer after each byte it loads. The pair is stored big-endian: the more significant register sits at the lower address. Pointer arithmetic is plain 16-bit modulo arithmetic with no range checking. Memory is synchronous, and read data returns one cycle after the read strobe.

Top module: `stk_seq`

## Requirements
- R1: The command code `cmd_op` is two bits. Bit 1 is the direction (0 = push, 1 = pop) and bit 0 is the pair (0 = pair A/B, 1 = pair C/D). A/C is the high register of each pair and B/D is the low register.
- R2: A push writes the low register to address SP-1 first and then the high register to address SP-2. Afterwards the SP has dropped by two and points at the high byte.
- R3: A pop reads the high register from address SP and then the low register from address SP+1. Afterwards the SP has risen by two.
- R4: The pair is stored big-endian, with the high register at the lower of its two addresses. A pop therefore restores the values that a matching push saved.
- R5: The SP wraps silently modulo 2^16. A push from 0x0000 leaves 0xFFFE, and a pop from 0xFFFE leaves 0x0000.
- R6: If the cycle in which a command is accepted is counted as cycle 1, `done` is high in cycle 4 for a push and in cycle 5 for a pop. `done` is high for exactly one cycle.
- R7: After reset the SP reads 0x0000, and `busy`, `done`, `mem_we`, `mem_re` and `rf_we` are low.
- R8: A command is accepted only while `busy` is low. A `cmd_valid` raised while busy has no effect on the SP, the memory or the registers.
- R9: `mem_we` and `mem_re` are never high in the same cycle, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_op | input | 2 | Bit 1 = direction (1 = pop), bit 0 = pair select |
| pair0_hi | input | 8 | Current value of register A |
| pair0_lo | input | 8 | Current value of register B |
| pair1_hi | input | 8 | Current value of register C |
| pair1_lo | input | 8 | Current value of register D |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data returns next cycle |
| mem_rdata | input | 8 | Memory read data |
| rf_we | output | 1 | Register write-back strobe |
| rf_pair | output | 1 | Pair written back (0 = A/B, 1 = C/D) |
| rf_hi | output | 1 | 1 = high register of the pair, 0 = low register |
| rf_wdata | output | 8 | Register write-back data |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | High while a command is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
During a pop, the pointer increment for the low byte and the write-back of the high byte fall in the same cycle. In that cycle the read for the second address is issued while the data from the first read is being consumed. The bench provokes this with push/pop sequences whose two bytes differ, and with a pop across the 0xFFFF to 0x0000 wrap. It then judges the register contents and the final pointer, so a swapped or stale byte shows up. A second overlap, a new command arriving while a sequence runs, is provoked by holding `cmd_valid` through a push. It is judged by checking that the pointer moved by exactly two and that the block then returns to idle.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_LO = 3'd1,
    ST_PUSH_HI = 3'd2,
    ST_POP_HI  = 3'd3,
    ST_POP_LO  = 3'd4,
    ST_POP_WB  = 3'd5,
    ST_DONE    = 3'd6
  } stk_state_e;

  // Control word from the sequencer to the pointer and datapath
  typedef struct packed {
    logic load_cmd;
    logic sp_dec;
    logic sp_inc;
    logic mem_we;
    logic mem_re;
    logic wr_hi;
    logic rf_we;
    logic rf_hi;
    logic done;
    logic busy;
  } stk_ctl_t;

  localparam int unsigned OP_W    = 2;
  localparam int unsigned OP_DIR  = 1;
  localparam int unsigned OP_PAIR = 0;

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  logic     cmd_pop,
  output stk_ctl_t ctl
);

  stk_state_e state_q;
  stk_state_e state_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          state_d = cmd_pop ? ST_POP_HI : ST_PUSH_LO;
        end
      end
      ST_PUSH_LO: state_d = ST_PUSH_HI;
      ST_PUSH_HI: state_d = ST_DONE;
      ST_POP_HI:  state_d = ST_POP_LO;
      ST_POP_LO:  state_d = ST_POP_WB;
      ST_POP_WB:  state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Output decode
  always_comb begin
    ctl = '0;
    unique case (state_q)
      ST_IDLE: begin
        ctl.load_cmd = cmd_valid;
      end
      ST_PUSH_LO: begin
        ctl.busy   = 1'b1;
        ctl.sp_dec = 1'b1;
        ctl.mem_we = 1'b1;
        ctl.wr_hi  = 1'b0;
      end
      ST_PUSH_HI: begin
        ctl.busy   = 1'b1;
        ctl.sp_dec = 1'b1;
        ctl.mem_we = 1'b1;
        ctl.wr_hi  = 1'b1;
      end
      ST_POP_HI: begin
        ctl.busy   = 1'b1;
        ctl.mem_re = 1'b1;
        ctl.sp_inc = 1'b1;
      end
      ST_POP_LO: begin
        ctl.busy   = 1'b1;
        ctl.mem_re = 1'b1;
        ctl.sp_inc = 1'b1;
        ctl.rf_we  = 1'b1;
        ctl.rf_hi  = 1'b1;
      end
      ST_POP_WB: begin
        ctl.busy   = 1'b1;
        ctl.rf_we  = 1'b1;
        ctl.rf_hi  = 1'b0;
      end
      ST_DONE: begin
        ctl.busy   = 1'b1;
        ctl.done   = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.done |=> !ctl.done); // R6

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.mem_we && ctl.mem_re)); // R9

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.busy && !ctl.done) |=> ctl.busy); // R8

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.done |=> !ctl.busy); // R6

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sp_dec,
  input  logic          sp_inc,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic          sp_en;
  logic [AW-1:0] sp_d;
  logic [AW-1:0] sp_minus;
  logic [AW-1:0] sp_plus;

  assign sp_minus = sp_q - ONE;
  assign sp_plus  = sp_q + ONE;
  assign sp_en    = sp_dec | sp_inc;

  always_comb begin
    sp_d = sp_q;
    if (sp_dec) begin
      sp_d = sp_minus;
    end else if (sp_inc) begin
      sp_d = sp_plus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  // Push pre-decrements: the store goes to the decremented address
  assign addr = sp_dec ? sp_minus : sp_q;

  AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp_dec && sp_inc)); // R9

endmodule

// File: rtl/stk_dpath.sv
module stk_dpath #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_cmd,
  input  logic          cmd_pair,
  input  logic [DW-1:0] pair0_hi,
  input  logic [DW-1:0] pair0_lo,
  input  logic [DW-1:0] pair1_hi,
  input  logic [DW-1:0] pair1_lo,
  input  logic          mem_we,
  input  logic          wr_hi,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          pair_q,
  output logic [DW-1:0] rf_wdata
);

  logic [DW-1:0] hi_q;
  logic [DW-1:0] lo_q;
  logic [DW-1:0] hi_d;
  logic [DW-1:0] lo_d;

  // Snapshot the selected pair when the command is taken
  always_comb begin
    hi_d = cmd_pair ? pair1_hi : pair0_hi;
    lo_d = cmd_pair ? pair1_lo : pair0_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      pair_q <= 1'b0;
    end else if (load_cmd) begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      pair_q <= cmd_pair;
    end
  end

  always_comb begin
    mem_wdata = '0;
    if (mem_we) begin
      mem_wdata = wr_hi ? hi_q : lo_q;
    end
  end

  assign rf_wdata = mem_rdata;

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic [DW-1:0]   pair0_hi,
  input  logic [DW-1:0]   pair0_lo,
  input  logic [DW-1:0]   pair1_hi,
  input  logic [DW-1:0]   pair1_lo,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  input  logic [DW-1:0]   mem_rdata,
  output logic            rf_we,
  output logic            rf_pair,
  output logic            rf_hi,
  output logic [DW-1:0]   rf_wdata,
  output logic [AW-1:0]   sp,
  output logic            busy,
  output logic            done
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic     rst_n_sync;
  stk_ctl_t ctl;

  stk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  stk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cmd_valid (cmd_valid),
    .cmd_pop   (cmd_op[OP_DIR]),
    .ctl       (ctl)
  );

  stk_ptr #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .sp_dec (ctl.sp_dec),
    .sp_inc (ctl.sp_inc),
    .sp_q   (sp),
    .addr   (mem_addr)
  );

  stk_dpath #(.DW(DW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load_cmd  (ctl.load_cmd),
    .cmd_pair  (cmd_op[OP_PAIR]),
    .pair0_hi  (pair0_hi),
    .pair0_lo  (pair0_lo),
    .pair1_hi  (pair1_hi),
    .pair1_lo  (pair1_lo),
    .mem_we    (ctl.mem_we),
    .wr_hi     (ctl.wr_hi),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .pair_q    (rf_pair),
    .rf_wdata  (rf_wdata)
  );

  assign mem_we = ctl.mem_we;
  assign mem_re = ctl.mem_re;
  assign rf_we  = ctl.rf_we;
  assign rf_hi  = ctl.rf_hi;
  assign busy   = ctl.busy;
  assign done   = ctl.done;

  AST_WRITE_LEAVES_SP: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_we |=> (sp == $past(mem_addr))); // R2

  AST_READ_ADVANCES_SP: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_re |=> (sp == $past(mem_addr) + ONE)); // R3

  AST_HI_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rf_we && rf_hi) |-> $past(mem_re)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !busy |-> !(mem_we || mem_re || rf_we)); // R9

endmodule

// File: tb/stk_seq_tb.sv
module stk_seq_tb;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] sp_exp;
    logic [7:0]  ehi;
    logic [7:0]  elo;
  } vec_t;

  // op: bit1 = pop, bit0 = pair C/D
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 8'h12, 8'h34, 16'hFFFE, 8'h12, 8'h34},
    '{2'b01, 8'h56, 8'h78, 16'hFFFC, 8'h56, 8'h78},
    '{2'b10, 8'h00, 8'h00, 16'hFFFE, 8'h56, 8'h78},
    '{2'b11, 8'h00, 8'h00, 16'h0000, 8'h12, 8'h34},
    '{2'b01, 8'h9A, 8'hBC, 16'hFFFE, 8'h9A, 8'hBC},
    '{2'b11, 8'h00, 8'h00, 16'h0000, 8'h9A, 8'hBC}
  };

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [7:0]  ra, rb, rc, rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic [7:0]  mem_rdata;
  logic        rf_we;
  logic        rf_pair;
  logic        rf_hi;
  logic [7:0]  rf_wdata;
  logic [15:0] sp;
  logic        busy;
  logic        done;

  logic        ld_en;
  logic        ld_pair;
  logic [7:0]  ld_hi;
  logic [7:0]  ld_lo;
  logic        log_clr;
  logic [15:0] wr0_addr;
  logic [7:0]  wr0_data;
  int          wr_cnt;
  int          both_cnt;

  logic [7:0]  mem [256];

  int checks;
  int errors;
  bit finished;

  stk_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .pair0_hi  (ra),
    .pair0_lo  (rb),
    .pair1_hi  (rc),
    .pair1_lo  (rd),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_rdata (mem_rdata),
    .rf_we     (rf_we),
    .rf_pair   (rf_pair),
    .rf_hi     (rf_hi),
    .rf_wdata  (rf_wdata),
    .sp        (sp),
    .busy      (busy),
    .done      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Synchronous memory, one-cycle read latency, with a write log
  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we && mem_re) both_cnt <= both_cnt + 1;
    if (log_clr) begin
      wr_cnt <= 0;
    end else if (mem_we) begin
      if (wr_cnt == 0) begin
        wr0_addr <= mem_addr;
        wr0_data <= mem_wdata;
      end
      wr_cnt <= wr_cnt + 1;
    end
  end

  // Register file model
  always_ff @(posedge clk) begin
    if (rf_we) begin
      case ({rf_pair, rf_hi})
        2'b01:   ra <= rf_wdata;
        2'b00:   rb <= rf_wdata;
        2'b11:   rc <= rf_wdata;
        default: rd <= rf_wdata;
      endcase
    end else if (ld_en) begin
      if (ld_pair) begin rc <= ld_hi; rd <= ld_lo; end
      else         begin ra <= ld_hi; rb <= ld_lo; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preset(input logic pair, input logic [7:0] h, input logic [7:0] l);
    @(negedge clk);
    ld_en = 1'b1; ld_pair = pair; ld_hi = h; ld_lo = l;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Issue one command; returns the cycle (accept = 1) in which done is high
  task automatic run_cmd(input logic [1:0] op, input bit hold, output int cyc);
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
    cmd_valid = 1'b1;
    cmd_op = op;
    cyc = 1;
    @(negedge clk);
    if (hold) cmd_op = ~op;
    else cmd_valid = 1'b0;
    cyc = 2;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    both_cnt = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00;
    ld_en = 1'b0; ld_pair = 1'b0; ld_hi = 8'h00; ld_lo = 8'h00;
    log_clr = 1'b1;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 sp", {16'h0, sp}, 32'h0);
    chk("R7 idle strobes", {27'h0, busy, done, mem_we, mem_re, rf_we}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 sp after release", {16'h0, sp}, 32'h0);
    chk("R7 busy after release", {31'h0, busy}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      int cyc;
      bit is_pop;
      is_pop = VECS[i].op[1];
      if (!is_pop) preset(VECS[i].op[0], VECS[i].hi, VECS[i].lo);
      run_cmd(VECS[i].op, 1'b0, cyc);
      // R1 R6: cycle count depends on direction bit
      chk($sformatf("R6 R1 vec%0d done cycle", i), cyc, is_pop ? 5 : 4);
      @(negedge clk);
      chk($sformatf("R6 vec%0d done pulse width", i), {31'h0, done}, 32'h0);
      chk($sformatf("R2 R3 R5 vec%0d sp", i), {16'h0, sp}, {16'h0, VECS[i].sp_exp});
      if (!is_pop) begin
        // R4: high at lower address; R2: low byte written first at SP-1
        chk($sformatf("R4 vec%0d mem hi", i), mem[VECS[i].sp_exp[7:0]], VECS[i].ehi);
        chk($sformatf("R4 vec%0d mem lo", i), mem[8'(VECS[i].sp_exp[7:0] + 8'd1)], VECS[i].elo);
        chk($sformatf("R2 vec%0d first write addr", i), {16'h0, wr0_addr}, {16'h0, VECS[i].sp_exp + 16'd1});
        chk($sformatf("R2 vec%0d first write data", i), wr0_data, VECS[i].elo);
      end else begin
        // R3 R4: pair restored from stack, pair chosen by bit 0 (R1)
        if (VECS[i].op[0]) begin
          chk($sformatf("R3 R1 vec%0d C", i), rc, VECS[i].ehi);
          chk($sformatf("R3 R1 vec%0d D", i), rd, VECS[i].elo);
        end else begin
          chk($sformatf("R3 R1 vec%0d A", i), ra, VECS[i].ehi);
          chk($sformatf("R3 R1 vec%0d B", i), rb, VECS[i].elo);
        end
      end
    end

    // R8: command held valid (with the opposite op) through a running push
    begin
      int cyc;
      preset(1'b0, 8'hC3, 8'h5A);
      run_cmd(2'b00, 1'b1, cyc);
      chk("R8 push done cycle with held cmd", cyc, 4);
      @(negedge clk);
      chk("R8 sp moved by exactly two", {16'h0, sp}, 32'h0000FFFE);
      chk("R8 idle after done", {31'h0, busy}, 32'h0);
      chk("R8 writes only two", wr_cnt, 2);
      chk("R8 A unchanged", ra, 8'hC3);
      chk("R8 B unchanged", rb, 8'h5A);
    end

    // R9: no cycle with both strobes; quiet while idle
    chk("R9 no simultaneous strobes", both_cnt, 0);
    chk("R9 idle strobes", {30'h0, mem_we, mem_re}, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule